// File: doc/BRIEF.md
# Self-Test Pattern Generator for a Deep Delay Line

This block is a built-in stimulus source for a long serial delay line. It has an 8-bit maximal-length linear feedback shift register (LFSR). When its step enable is high, the register advances once per clock and emits a serial pattern bit. A marker output goes high for a single cycle each time the sequence comes round to its wrap state. The reset state is worked out when the design is built so that the first marker arrives exactly 193 advancing cycles after reset is released.

Two selects set how the block is wired into the delay line. The source select feeds the delay line from either the external data pin or the pattern bit. The display select puts either the LFSR state or the eight phase pulses of the delay line's sequencer onto the 8-bit observation bus.

The pattern repeats every 255 cycles. A delay line of 791 stages is three full periods plus 26 cycles, so the delayed stream can be compared against the live pattern with a fixed offset.

Top module: `selftest_pattern_gen`

## Requirements
- R1: A synchronous active-low reset loads the register with its reset state and drives the wrap marker low. The reset state is the unique non-zero value that first reaches 8'h01 after exactly 193 advances.
- R2: On each clock edge with the step enable high and reset inactive, the state s becomes {s[6:0], s[7]^s[5]^s[4]^s[3]}. The pattern bit output is always state bit 7.
- R3: While the step enable is low, the state does not change.
- R4: The state is never zero. After 255 advances it is back at the reset state.
- R5: The wrap marker is high for exactly one cycle, in the cycle that follows an advance into state 8'h01. The first such pulse follows the 193rd advance after reset release.
- R6: The wrap marker is low in any cycle that does not directly follow an advancing edge.
- R7: When the source select is 1, the delay-line input equals the pattern bit. When it is 0, the delay-line input equals the external data pin.
- R8: When the display select is 1, bit i of the observation bus is state bit i. When it is 0, the bus equals the phase pulse input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en_i | input | 1 | Allows the LFSR to advance |
| src_sel_i | input | 1 | 1: the pattern bit feeds the delay line, 0: the external pin does |
| ext_din_i | input | 1 | External data pin |
| show_state_i | input | 1 | 1: the bus shows the LFSR state, 0: it shows the phase pulses |
| phase_i | input | 8 | Phase pulses from the delay-line sequencer |
| pat_bit_o | output | 1 | Serial pattern bit |
| wrap_mark_o | output | 1 | One-cycle wrap marker |
| line_din_o | output | 1 | Delay-line input after source selection |
| obs_o | output | 8 | Observation bus |

## Verification
The bench targets the first marker position directly. A reset state worked out from the wrong tap set or a wrong rewind count would move the first pulse away from the 193rd advance, and an off-by-one in the marker register would shift it by one cycle. It drops the step enable in the very cycle the marker is high. A marker derived from the state alone, rather than from the advance, would then stay high while the state is held. It also runs past a full 255-step period to catch a tap set that is not maximal or that reaches zero. Finally, it toggles both selects and the phase input against a changing external pin, so that a swapped or stuck mux leg shows up as a mismatch.

// File: rtl/stgen_pkg.sv
`timescale 1ns/1ps
// Shared constants for the self-test pattern generator.
// Assumes an LFSR width of at least 2; the tap mask must describe a
// primitive polynomial for the period to be maximal.
package stgen_pkg;
    localparam int unsigned LFSR_W     = 8;
    // taps 8,6,5,4 mapped onto state bits 7,5,4,3
    localparam logic [LFSR_W-1:0] TAP_MASK   = 8'hB8;
    localparam logic [LFSR_W-1:0] WRAP_STATE = 8'h01;
    localparam int unsigned FIRST_WRAP = 193;
endpackage

// File: rtl/stgen_lfsr_core.sv
`timescale 1ns/1ps
// Fibonacci LFSR that shifts toward the MSB and feeds parity of the tapped
// bits into bit 0. The reset state is derived at elaboration: it is the
// wrap state stepped forward (PERIOD - FIRST_WRAP) times, so that after
// FIRST_WRAP advances it reaches the wrap state. Assumes FIRST_WRAP < PERIOD.
module stgen_lfsr_core #(
    parameter int unsigned       W          = stgen_pkg::LFSR_W,
    parameter logic [W-1:0]      TAPS       = stgen_pkg::TAP_MASK,
    parameter logic [W-1:0]      WRAP_STATE = stgen_pkg::WRAP_STATE,
    parameter int unsigned       FIRST_WRAP = stgen_pkg::FIRST_WRAP
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    output logic [W-1:0] state_o,
    output logic [W-1:0] next_o,
    output logic         bit_o
);
    localparam int unsigned PERIOD = (1 << W) - 1;
    localparam int unsigned REWIND = PERIOD - FIRST_WRAP;

    function automatic logic [W-1:0] step_fn(input logic [W-1:0] s);
        return {s[W-2:0], ^(s & TAPS)};
    endfunction

    function automatic logic [W-1:0] rewind_fn(input logic [W-1:0] anchor);
        logic [W-1:0] s;
        s = anchor;
        for (int k = 0; k < int'(REWIND); k++) begin
            s = step_fn(s);
        end
        return s;
    endfunction

    localparam logic [W-1:0] RESET_STATE = rewind_fn(WRAP_STATE);

    logic [W-1:0] state_q;

    // next value of the register if it advances this cycle
    always_comb begin
        next_o = step_fn(state_q);
    end

    // state register: reset load, advance on enable, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESET_STATE;
        end else if (adv_i) begin
            state_q <= next_o;
        end
    end

    assign state_o = state_q;
    assign bit_o   = state_q[W-1];

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(state_q)); // R3
    AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> state_q[W-1:1] == $past(state_q[W-2:0])); // R2
    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0); // R4
endmodule

// File: rtl/stgen_wrap_mark.sv
`timescale 1ns/1ps
// Wrap marker: registers a one-cycle pulse when the LFSR advances into the
// wrap state. Assumes the wrap state is not a fixed point of the step.
module stgen_wrap_mark #(
    parameter int unsigned  W          = stgen_pkg::LFSR_W,
    parameter logic [W-1:0] WRAP_STATE = stgen_pkg::WRAP_STATE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    input  logic [W-1:0] next_i,
    output logic         mark_o
);
    logic mark_q;

    // marker register: set only by an advance landing on the wrap state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_q <= 1'b0;
        end else begin
            mark_q <= adv_i && (next_i == WRAP_STATE);
        end
    end

    assign mark_o = mark_q;

    AST_MARK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mark_q |=> !mark_q); // R5
    AST_MARK_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mark_q |-> $past(adv_i)); // R6
endmodule

// File: rtl/stgen_route.sv
`timescale 1ns/1ps
// Output routing: picks the delay-line source and the observation bus
// content. Purely combinational; assumes selects are stable per cycle.
module stgen_route #(
    parameter int unsigned W = stgen_pkg::LFSR_W
) (
    input  logic         src_sel_i,
    input  logic         ext_din_i,
    input  logic         pat_bit_i,
    input  logic         show_state_i,
    input  logic [W-1:0] state_i,
    input  logic [W-1:0] phase_i,
    output logic         line_din_o,
    output logic [W-1:0] obs_o
);
    // delay-line source select
    always_comb begin
        line_din_o = src_sel_i ? pat_bit_i : ext_din_i;
    end

    for (genvar i = 0; i < int'(W); i++) begin : g_obs
        // per-lane observation select
        always_comb begin
            obs_o[i] = show_state_i ? state_i[i] : phase_i[i];
        end
    end
endmodule

// File: rtl/selftest_pattern_gen.sv
`timescale 1ns/1ps
// Top of the self-test pattern generator: LFSR core, wrap marker and
// output routing. Assumes one clock domain and a synchronous reset.
module selftest_pattern_gen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_en_i,
    input  logic       src_sel_i,
    input  logic       ext_din_i,
    input  logic       show_state_i,
    input  logic [7:0] phase_i,
    output logic       pat_bit_o,
    output logic       wrap_mark_o,
    output logic       line_din_o,
    output logic [7:0] obs_o
);
    localparam int unsigned W = stgen_pkg::LFSR_W;

    logic [W-1:0] state_w;
    logic [W-1:0] next_w;
    logic         bit_w;

    stgen_lfsr_core #(
        .W          (W),
        .TAPS       (stgen_pkg::TAP_MASK),
        .WRAP_STATE (stgen_pkg::WRAP_STATE),
        .FIRST_WRAP (stgen_pkg::FIRST_WRAP)
    ) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (step_en_i),
        .state_o (state_w),
        .next_o  (next_w),
        .bit_o   (bit_w)
    );

    stgen_wrap_mark #(
        .W          (W),
        .WRAP_STATE (stgen_pkg::WRAP_STATE)
    ) mark_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (step_en_i),
        .next_i (next_w),
        .mark_o (wrap_mark_o)
    );

    stgen_route #(
        .W (W)
    ) route_i (
        .src_sel_i    (src_sel_i),
        .ext_din_i    (ext_din_i),
        .pat_bit_i    (bit_w),
        .show_state_i (show_state_i),
        .state_i      (state_w),
        .phase_i      (phase_i),
        .line_din_o   (line_din_o),
        .obs_o        (obs_o)
    );

    assign pat_bit_o = bit_w;
endmodule

// File: tb/selftest_pattern_gen_tb_top.sv
`timescale 1ns/1ps
module selftest_pattern_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_en_i = 1'b0;
    logic       src_sel_i = 1'b0;
    logic       ext_din_i = 1'b0;
    logic       show_state_i = 1'b1;
    logic [7:0] phase_i = 8'h00;
    logic       pat_bit_o;
    logic       wrap_mark_o;
    logic       line_din_o;
    logic [7:0] obs_o;

    always #10 clk = ~clk;

    selftest_pattern_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_en_i    (step_en_i),
        .src_sel_i    (src_sel_i),
        .ext_din_i    (ext_din_i),
        .show_state_i (show_state_i),
        .phase_i      (phase_i),
        .pat_bit_o    (pat_bit_o),
        .wrap_mark_o  (wrap_mark_o),
        .line_din_o   (line_din_o),
        .obs_o        (obs_o)
    );

    typedef struct {
        logic [7:0] st;
        logic       mk;
        logic       din;
        logic [7:0] obs;
        logic       rst;
        logic       adv;
        logic       show;
    } exp_t;

    exp_t       sb_q[$];
    int         total = 0;
    int         bad = 0;
    bit         done = 0;
    logic [7:0] m_state;
    logic [7:0] reset_val;
    logic [15:0] lcg = 16'hACE1;

    // step rule from R2
    function automatic logic [7:0] ref_step(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    // reset state per R1: first reaches 8'h01 after exactly 193 advances
    function automatic logic [7:0] find_reset();
        for (int c = 1; c < 256; c++) begin
            logic [7:0] s;
            bit early;
            s = 8'(c);
            early = 0;
            for (int k = 1; k <= 193; k++) begin
                s = ref_step(s);
                if (s == 8'h01 && k < 193) early = 1;
            end
            if (!early && s == 8'h01) return 8'(c);
        end
        return 8'h00;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    // driver: applies one cycle of inputs and queues the expected result
    task automatic drive(input logic r, input logic e, input logic s,
                         input logic x, input logic sh, input logic [7:0] ph);
        exp_t it;
        @(negedge clk);
        rst_n = r; step_en_i = e; src_sel_i = s; ext_din_i = x;
        show_state_i = sh; phase_i = ph;
        it.mk = 1'b0;
        if (!r) begin
            m_state = reset_val;
        end else if (e) begin
            m_state = ref_step(m_state);
            it.mk = (m_state == 8'h01);
        end
        it.st   = m_state;
        it.din  = s ? m_state[7] : x;
        it.obs  = sh ? m_state : ph;
        it.rst  = r;
        it.adv  = r && e;
        it.show = sh;
        sb_q.push_back(it);
    endtask

    // monitor: samples outputs mid-cycle and compares with the queue head
    initial begin
        int  cnt;
        bit  first;
        cnt = 0;
        first = 1;
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                if (!e.rst) begin
                    cnt = 0; first = 1;
                    check(obs_o == reset_val, "R1 reset state on bus", obs_o, reset_val);
                    check(wrap_mark_o == 1'b0, "R1 marker low in reset", wrap_mark_o, 0);
                end else begin
                    if (e.adv) cnt++;
                    check(pat_bit_o == e.st[7], "R2 pattern bit", pat_bit_o, e.st[7]);
                    if (e.show) begin
                        check(obs_o == e.st, "R2/R3 state on bus", obs_o, e.st);
                        check(obs_o != 8'h00, "R4 nonzero state", obs_o, 1);
                        if (cnt == 255 && e.adv)
                            check(obs_o == reset_val, "R4 period 255", obs_o, reset_val);
                    end
                    check(wrap_mark_o == e.mk, e.adv ? "R5 wrap marker" : "R6 marker while held",
                          wrap_mark_o, e.mk);
                    if (wrap_mark_o && first) begin
                        first = 0;
                        check(cnt == 193, "R5 first marker position", cnt, 193);
                    end
                end
                check(line_din_o == e.din, "R7 delay-line source", line_din_o, e.din);
                check(obs_o == e.obs, "R8 observation bus", obs_o, e.obs);
            end
        end
    end

    // watchdog
    initial begin
        #4_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired act=1 exp=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // stimulus
    initial begin
        reset_val = find_reset();
        m_state = reset_val;
        // R1: reset held for a few cycles
        for (int i = 0; i < 4; i++) drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        // R2 R4 R5 R7: free run past one period, external pin changing
        for (int i = 0; i < 300; i++) begin
            lcg = {lcg[14:0], lcg[15] ^ lcg[13] ^ lcg[12] ^ lcg[10]};
            drive(1'b1, 1'b1, (i % 7) != 3, lcg[0], 1'b1, 8'h00);
        end
        // R3 R6: reset, run to the first marker, then drop enable on it
        for (int i = 0; i < 2; i++) drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
        for (int i = 0; i < 193; i++) drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        for (int i = 0; i < 6; i++) drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
        for (int i = 0; i < 10; i++) drive(1'b1, (i % 2) == 0, 1'b1, 1'b0, 1'b1, 8'h00);
        // R8 R7: phase pulses on the bus, external source selected
        for (int i = 0; i < 24; i++) begin
            lcg = {lcg[14:0], lcg[15] ^ lcg[13] ^ lcg[12] ^ lcg[10]};
            drive(1'b1, 1'b1, 1'b0, lcg[3], 1'b0, 8'h01 << (i % 8));
        end
        // R8: bus switching back and forth
        for (int i = 0; i < 16; i++) drive(1'b1, 1'b1, i[0], i[1], i[2], 8'hA5 ^ 8'(i));
        // R1: reset mid-run
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        for (int i = 0; i < 20; i++) drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        repeat (3) @(posedge clk);
        #6;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule